// File: doc/BRIEF.md
# Late-Write Flow-Through Synchronous Burst SRAM

This block is a synthesizable single-port synchronous SRAM. Reads are flow-through: the word addressed by a read command appears on the data output in the cycle right after the clock edge that accepted the command. Writes are late: the edge that accepts a write command takes its address and byte enables, and the word itself is taken from the data input on the next enabled edge. Write latency therefore equals read latency, and reads and writes can be issued in any order on consecutive cycles with no idle bus cycle between them.

A burst-advance input continues the previous operation (read, write or deselect) at an address made by an internal two-bit counter. A burst-order input selects a linear or an interleaved sequence. An active-low clock enable freezes everything, including a write whose data is still due. The bidirectional data bus is modelled as a separate input, output and drive-enable. Three active-low chip enables must all be asserted to select the device. The output drive is further gated by an active-low output enable.

Top module: `lw_sram`

## Requirements
- R1: With all chip enables low, `adv` low and `rw_n` low, an enabled edge accepts a write to `addr`. The word on `din` at the next enabled edge is stored at that address.
- R2: With all chip enables low, `adv` low and `rw_n` high, an enabled edge accepts a read. In the cycle after that edge, `dout` holds the stored word and `dout_en` is high if `oe_n` is low.
- R3: Reads and writes issued on consecutive enabled edges, in any order and to the same address, need no idle cycle. A read accepted on the edge that takes a write's data returns that new data.
- R4: Byte lane i is bits [8i+7:8i]. A write updates lane i only when `be_n[i]`, sampled with the write command, is 0. All other lanes keep their old contents.
- R5: When `adv` is high at an enabled edge, `addr`, `ce_n` and `rw_n` are ignored and the previous operation type continues. With `order_sel` = 0 the two low address bits step as start+n modulo 4, and the upper address bits stay fixed.
- R6: With `order_sel` = 1, the n-th burst address has low bits equal to start XOR n.
- R7: While `cke_n` is high, no edge changes any state: a due write datum is not taken, and `dout`/`dout_en` hold as long as `oe_n` is unchanged.
- R8: An accepted command with any one of the three chip enables high is a deselect: `dout_en` is low in the next cycle. It stays low through burst advances of that deselect.
- R9: `dout_en` is low whenever `oe_n` is high. It is also low in the cycle in which write data is expected on `din`.
- R10: After reset, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| ce_n | input | 3 | Three active-low chip enables, all low to select |
| rw_n | input | 1 | 1 = read, 0 = write |
| adv | input | 1 | 1 = continue burst from internal counter |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| be_n | input | DW/8 | Active-low byte write enables |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | DW | Write data, one enabled edge after the command |
| oe_n | input | 1 | Active-low output enable |
| dout | output | DW | Read data |
| dout_en | output | 1 | Output drive enable (high = bus driven) |

## Verification
Two functions can fall on the same edge: the late capture of a write datum, and the acceptance of a read to that same address. The bench provokes this by issuing a write and then, on the very next cycle, a read of that address while the write's data sits on `din`. A pass requires the read to return the new word in the following cycle. The same overlap happens inside bursts and around stalls: burst-write data lands while the counter advances, and a stall falls between a write command and its data. The bench judges each case by reading the words back afterwards.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
  localparam int BURST_BITS = 2;
endpackage

// File: rtl/lw_burst_ctr.sv
module lw_burst_ctr
  import lw_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          adv,
  input  logic          sel,
  input  logic          rw_n,
  input  logic          order_sel,
  input  logic [AW-1:0] addr,
  output op_e           cur_op,
  output logic [AW-1:0] cur_addr
);
  localparam int BB = BURST_BITS;

  op_e           op_q;
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q;
  logic [BB-1:0] cnt_d;
  logic [AW-1:0] base_d;
  logic [BB-1:0] lo;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    base_d = base_q;
    if (order_sel) lo = base_q[BB-1:0] ^ cnt_d;
    else           lo = base_q[BB-1:0] + cnt_d;
    if (adv) begin
      cur_op   = op_q;
      cur_addr = {base_q[AW-1:BB], lo};
    end else begin
      cnt_d    = '0;
      base_d   = addr;
      cur_addr = addr;
      if (!sel)      cur_op = OP_IDLE;
      else if (rw_n) cur_op = OP_READ;
      else           cur_op = OP_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      op_q   <= cur_op;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = DW / 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NB-1:0] wbe_n,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && !wbe_n[g]) lane_mem[waddr] <= wdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = lane_mem[raddr];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic [2:0]    ce_n,
  input  logic          rw_n,
  input  logic          adv,
  input  logic          order_sel,
  input  logic [NB-1:0] be_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          en;
  logic          sel;
  op_e           cur_op;
  logic [AW-1:0] cur_addr;

  logic          rd_vld_q, rd_vld_d;
  logic [AW-1:0] rd_addr_q, rd_addr_d;
  logic          wr_pend_q, wr_pend_d;
  logic [AW-1:0] wr_addr_q, wr_addr_d;
  logic [NB-1:0] wr_be_q, wr_be_d;

  assign en  = !cke_n;
  assign sel = (ce_n == 3'b000);

  lw_burst_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .adv      (adv),
    .sel      (sel),
    .rw_n     (rw_n),
    .order_sel(order_sel),
    .addr     (addr),
    .cur_op   (cur_op),
    .cur_addr (cur_addr)
  );

  always_comb begin
    rd_vld_d  = (cur_op == OP_READ);
    rd_addr_d = rd_addr_q;
    wr_pend_d = (cur_op == OP_WRITE);
    wr_addr_d = wr_addr_q;
    wr_be_d   = wr_be_q;
    if (cur_op == OP_READ)  rd_addr_d = cur_addr;
    if (cur_op == OP_WRITE) begin
      wr_addr_d = cur_addr;
      wr_be_d   = be_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
      wr_pend_q <= 1'b0;
      wr_addr_q <= '0;
      wr_be_q   <= '1;
    end else if (en) begin
      rd_vld_q  <= rd_vld_d;
      rd_addr_q <= rd_addr_d;
      wr_pend_q <= wr_pend_d;
      wr_addr_q <= wr_addr_d;
      wr_be_q   <= wr_be_d;
    end
  end

  lw_array #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk  (clk),
    .we   (en && wr_pend_q),
    .waddr(wr_addr_q),
    .wbe_n(wr_be_q),
    .wdata(din),
    .raddr(rd_addr_q),
    .rdata(dout)
  );

  assign dout_en = rd_vld_q && !oe_n;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic [2:0]    ce_n,
  input logic          rw_n,
  input logic          adv,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          dout_en
);
  // R8
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && ce_n != 3'b000) |=> !dout_en);
  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && ce_n == 3'b000 && rw_n) |=> (oe_n || dout_en));
  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && ce_n == 3'b000 && !rw_n) |=> !dout_en);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && dout_en) |=> (oe_n || (dout_en && $stable(dout))));
  // R5
  burst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && dout_en) |=> (oe_n || dout_en));
endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cke_n  (cke_n),
  .ce_n   (ce_n),
  .rw_n   (rw_n),
  .adv    (adv),
  .oe_n   (oe_n),
  .dout   (dout),
  .dout_en(dout_en)
);

// File: tb/lw_sram_tb.sv
module lw_sram_tb;
  localparam int AW = 6;
  localparam logic [2:0] SEL = 3'b000;
  localparam logic [2:0] DSL = 3'b111;

  logic          clk = 1'b0;
  logic          rst_n, cke_n, rw_n, adv, order_sel, oe_n;
  logic [2:0]    ce_n;
  logic [3:0]    be_n;
  logic [AW-1:0] addr;
  logic [31:0]   din, dout;
  logic          dout_en;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  lw_sram u_dut (.clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_n(ce_n), .rw_n(rw_n),
    .adv(adv), .order_sel(order_sel), .be_n(be_n), .addr(addr), .din(din),
    .oe_n(oe_n), .dout(dout), .dout_en(dout_en));

  task automatic issue(input logic [2:0] c, input logic rw, input logic a,
                       input logic [AW-1:0] ad, input logic [3:0] be, input logic [31:0] d);
    cke_n = 0; ce_n = c; rw_n = rw; adv = a; addr = ad; be_n = be; din = d;
    @(negedge clk);
  endtask

  task automatic check_rd(input string req, input logic [31:0] exp);
    total++;
    if (!dout_en || dout !== exp) begin
      bad++;
      $display("FAIL %s: dout_en=%0b dout=%h expected en=1 dout=%h", req, dout_en, dout, exp);
    end
  endtask

  task automatic check_off(input string req);
    total++;
    if (dout_en !== 1'b0) begin
      bad++;
      $display("FAIL %s: dout_en=%0b expected 0", req, dout_en);
    end
  endtask

  task automatic t_reset();
    check_off("R10");
  endtask

  task automatic t_write_read();
    issue(SEL, 0, 0, 5, 0, 0);
    issue(SEL, 0, 0, 6, 0, 32'hA5A5_0001);
    check_off("R9 write-data cycle");
    issue(SEL, 1, 0, 5, 0, 32'hB6B6_0002);
    check_rd("R1 R2 read 5", 32'hA5A5_0001);
    issue(SEL, 1, 0, 6, 0, 0);
    check_rd("R2 read 6", 32'hB6B6_0002);
    issue(SEL, 0, 0, 7, 0, 0);
    issue(SEL, 1, 0, 7, 0, 32'hC7C7_0003);
    check_rd("R3 same-edge read after write", 32'hC7C7_0003);
    issue(SEL, 0, 0, 7, 0, 0);
    issue(SEL, 1, 0, 5, 0, 32'hD8D8_0004);
    check_rd("R3 W-R mixed", 32'hA5A5_0001);
    issue(SEL, 1, 0, 7, 0, 0);
    check_rd("R3 read back", 32'hD8D8_0004);
  endtask

  task automatic t_bytes();
    issue(SEL, 0, 0, 3, 4'b0000, 0);
    issue(SEL, 0, 0, 3, 4'b1010, 32'h1122_3344);
    issue(SEL, 1, 0, 3, 4'b0000, 32'hAABB_CCDD);
    check_rd("R4 lanes 0,2", 32'h11BB_33DD);
  endtask

  task automatic t_bursts();
    for (int i = 8; i < 12; i++)
      issue(SEL, 0, 0, AW'(i), 0, (i == 8) ? 32'h0 : 32'h100 + i - 1);
    issue(DSL, 1, 0, 0, 0, 32'h10B);
    order_sel = 0;
    issue(SEL, 1, 0, 10, 0, 0);   check_rd("R5 lin 0", 32'h10A);
    issue(DSL, 0, 1, 33, 0, 0);   check_rd("R5 lin 1", 32'h10B);
    issue(DSL, 0, 1, 33, 0, 0);   check_rd("R5 lin 2", 32'h108);
    issue(DSL, 0, 1, 33, 0, 0);   check_rd("R5 lin 3", 32'h109);
    order_sel = 1;
    issue(SEL, 1, 0, 9, 0, 0);    check_rd("R6 int 0", 32'h109);
    issue(SEL, 0, 1, 40, 0, 0);   check_rd("R6 int 1", 32'h108);
    issue(SEL, 0, 1, 40, 0, 0);   check_rd("R6 int 2", 32'h10B);
    issue(SEL, 0, 1, 40, 0, 0);   check_rd("R6 int 3", 32'h10A);
    order_sel = 0;
    issue(SEL, 0, 0, 14, 0, 0);
    issue(SEL, 1, 1, 1, 0, 32'hD0);
    issue(SEL, 1, 1, 1, 0, 32'hD1);
    issue(SEL, 1, 1, 1, 0, 32'hD2);
    issue(DSL, 1, 0, 0, 0, 32'hD3);
    issue(SEL, 1, 0, 12, 0, 0);   check_rd("R5 burst write 12", 32'hD2);
    issue(SEL, 1, 0, 13, 0, 0);   check_rd("R5 burst write 13", 32'hD3);
    issue(SEL, 1, 0, 14, 0, 0);   check_rd("R5 burst write 14", 32'hD0);
    issue(SEL, 1, 0, 15, 0, 0);   check_rd("R5 burst write 15", 32'hD1);
  endtask

  task automatic t_stall();
    issue(SEL, 0, 0, 20, 0, 0);
    cke_n = 1; ce_n = SEL; rw_n = 0; addr = 21; din = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk);
    issue(DSL, 1, 0, 0, 0, 32'h2020_2020);
    issue(SEL, 1, 0, 20, 0, 0);
    check_rd("R7 late data after stall", 32'h2020_2020);
    cke_n = 1; rw_n = 0; addr = 21; din = 32'h5555_AAAA;
    @(negedge clk); @(negedge clk);
    check_rd("R7 output held in stall", 32'h2020_2020);
    issue(SEL, 1, 0, 21, 0, 0);
    check_rd("R7 no write during stall", 32'h0);
  endtask

  task automatic t_desel();
    for (int k = 0; k < 3; k++) begin
      issue(SEL, 1, 0, 20, 0, 0);
      issue(3'b001 << k, 1, 0, 20, 0, 0);
      check_off("R8 one enable high");
    end
    issue(SEL, 1, 1, 20, 0, 0);
    check_off("R8 deselect burst");
    oe_n = 1;
    issue(SEL, 1, 0, 20, 0, 0);
    check_off("R9 oe_n high");
    oe_n = 0;
    issue(DSL, 1, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; cke_n = 0; ce_n = DSL; rw_n = 1; adv = 0; order_sel = 0;
    oe_n = 0; be_n = '1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    issue(SEL, 0, 0, 21, 0, 0);
    issue(DSL, 1, 0, 0, 0, 32'h0);
    t_write_read();
    t_bytes();
    t_bursts();
    t_stall();
    t_desel();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule